// File: doc/BRIEF.md
# Mode-Aware Register and Status Unit

This block holds the programmer-visible state of a 16-bit processor core that can also run in an 8-bit compatibility ("emulation") mode. It stores the accumulator, the two index registers, the stack pointer, the direct-page register, two bank registers, the processor status byte, the emulation flag and a free-running cycle counter. It enforces the width rules that the mode bits impose on every write. In emulation mode the stack pointer is held in page one. While the 8-bit-index status flag is set, the upper bytes of both index registers stay zero.

Writes arrive on a single write port with a register select, 16-bit data and a byte-width flag. The write can also load the zero and negative flags from the value being written. The status byte can be loaded whole, or edited through clear and set masks. A test mask reports whether all of the chosen flags are set. A synchronous active-low power-on reset and a separate warm-reset input give the two initialisation behaviours. Instruction decode, the ALU and the memory side live elsewhere. All read-outs come straight from the stored state.

Top module: `cpu_reg_status`

## Requirements
- R1: After power-on reset (rst_n low at a clock edge) the unit reads SP = 0x01FF, status = 0x34, emulation flag = 1, cycle count = 0, and zero in A, X, Y, direct page and both bank registers.
- R2: The status bits are C=bit0, Z=bit1, I=bit2, D=bit3, X(8-bit index)=bit4, M(8-bit memory)=bit5, V=bit6, N=bit7. test_hit is 1 exactly when every bit set in test_mask is also set in the status byte, and it is combinational.
- R3: While the emulation flag (after the edge) is 1, the stored SP is 0x0100 OR the low byte of the value that would otherwise be stored. This covers SP writes and the edge that enters emulation mode. With the flag at 0, all 16 bits are stored.
- R4: wr_sel encodes 0=A, 1=X, 2=Y, 3=SP, 4=direct page, 5=data bank, 6=program bank, 7=none. A write with wr_byte=1 replaces only the low byte of the target and keeps its high byte. With wr_byte=0 all 16 bits are replaced. Bank registers take wr_data[7:0].
- R5: Whenever the status X bit is 1 after an edge, X[15:8] and Y[15:8] are 0. This holds whether the bit was set by a status write, by the set mask, or was already set when a 16-bit index write arrived.
- R6: A write with wr_nz=1 sets Z when the written value is zero and clears it otherwise. It sets N only when the value is nonzero and its top bit is 1 (bit 7 for a byte write, bit 15 otherwise). No other status bit changes.
- R7: In one cycle, flg_clr is applied first and flg_set second, and the zero/negative update is applied after both. A whole-status write (ps_we) overrides the masks and the zero/negative update.
- R8: A warm reset sets I, M and X and clears D, leaving the other status bits unchanged. It also sets emulation mode, zeroes the direct page and both bank registers, truncates X and Y to 8 bits, pins SP to page one and keeps A. It overrides every write in the same cycle.
- R9: The cycle counter increments by one each clock and reads 0 in the cycle after a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| warm_rst | input | 1 | Warm reset request, one clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R4) |
| wr_byte | input | 1 | 1: write low byte only |
| wr_nz | input | 1 | Update Z/N from the written value |
| wr_data | input | 16 | Write data |
| ps_we | input | 1 | Load whole status byte |
| ps_data | input | 8 | Status load value |
| flg_clr | input | 8 | Status bits to clear |
| flg_set | input | 8 | Status bits to set |
| emu_we | input | 1 | Emulation flag write strobe |
| emu_data | input | 1 | Emulation flag value |
| test_mask | input | 8 | Flags to test |
| test_hit | output | 1 | All tested flags set |
| a_q | output | 16 | Accumulator |
| x_q | output | 16 | X index |
| y_q | output | 16 | Y index |
| sp_q | output | 16 | Stack pointer |
| dp_q | output | 16 | Direct page register |
| dbank_q | output | 8 | Data bank register |
| pbank_q | output | 8 | Program bank register |
| ps_q | output | 8 | Status byte |
| emu_q | output | 1 | Emulation flag |
| cyc_q | output | 32 | Cycle counter |

## Verification
The assertions assume that the only way to change state is the documented inputs. They treat wr_nz as meaningful only together with wr_en. Their zero/negative exclusivity check applies only in cycles with no whole-status write and no warm reset, because a status load or a set mask may legitimately raise both flags. The byte-write check assumes that a single write port can target only one register per cycle. The directed stimulus drives at most one write per cycle, always raises wr_nz together with wr_en, and keeps every input stable across each active edge. It also combines a warm reset with a competing write in the same cycle, to exercise the override.

// File: rtl/cpu_reg_pkg.sv
// Shared types and constants for the register and status unit.
// Assumes an 8-bit status byte and byte-granular partial writes.
package cpu_reg_pkg;

    typedef enum logic [2:0] {
        SEL_A     = 3'd0,
        SEL_X     = 3'd1,
        SEL_Y     = 3'd2,
        SEL_SP    = 3'd3,
        SEL_DP    = 3'd4,
        SEL_DBANK = 3'd5,
        SEL_PBANK = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_X = 4;
    localparam int FLG_M = 5;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

    localparam logic [7:0] PS_FORCE_ON  = (8'h1 << FLG_I) | (8'h1 << FLG_M) | (8'h1 << FLG_X);
    localparam logic [7:0] PS_FORCE_OFF = (8'h1 << FLG_D);

endpackage

// File: rtl/crs_status.sv
// Status byte: whole loads, clear/set masks, Z/N update, flag test.
// Assumes nz_en is only raised together with a register write.
module crs_status
    import cpu_reg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          ps_we,
    input  logic [7:0]    ps_data,
    input  logic [7:0]    flg_clr,
    input  logic [7:0]    flg_set,
    input  logic          nz_en,
    input  logic          nz_byte,
    input  logic [DW-1:0] nz_val,
    input  logic [7:0]    test_mask,
    output logic [7:0]    p_q,
    output logic [7:0]    p_next,
    output logic          test_hit
);

    logic [DW-1:0] nz_view;
    logic          nz_zero;
    logic          nz_neg;

    // Width-select the value feeding the zero/negative update.
    always_comb begin
        nz_view = nz_byte ? {{(DW-8){1'b0}}, nz_val[7:0]} : nz_val;
        nz_zero = (nz_view == '0);
        nz_neg  = nz_byte ? nz_val[7] : nz_val[DW-1];
    end

    // Next status: warm reset, whole load, or clear-set-then-Z/N.
    always_comb begin
        p_next = p_q;
        if (warm_rst) begin
            p_next = (p_q | PS_FORCE_ON) & ~PS_FORCE_OFF;
        end else if (ps_we) begin
            p_next = ps_data;
        end else begin
            p_next = (p_q & ~flg_clr) | flg_set;
            if (nz_en) begin
                p_next[FLG_Z] = nz_zero;
                p_next[FLG_N] = !nz_zero && nz_neg;
            end
        end
    end

    // Status register with power-on value.
    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= PS_FORCE_ON;
        else        p_q <= p_next;
    end

    // Flag test is a pure read of the stored byte.
    assign test_hit = ((p_q & test_mask) == test_mask);

    AST_NZ_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_en && !ps_we && !warm_rst) |=> !(p_q[FLG_Z] && p_q[FLG_N])); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_we && !warm_rst) |=> (p_q == $past(ps_data))); // R7
    AST_WARM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (p_q[FLG_I] && p_q[FLG_M] && p_q[FLG_X] && !p_q[FLG_D])); // R8

endmodule

// File: rtl/crs_gpr.sv
// Accumulator and index registers with byte-write merge and index truncation.
// Assumes idx8_next is the status X bit that the same edge will store.
module crs_gpr
    import cpu_reg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    input  logic          idx8_next,
    input  logic          idx8_q,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] x_q,
    output logic [DW-1:0] y_q
);

    localparam int NREG = 3;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam bit IS_INDEX = (i != 0);
        logic [DW-1:0] q;
        logic [DW-1:0] nxt;

        // Merge the write, then apply the index width rule.
        always_comb begin
            nxt = q;
            if (warm_rst) begin
                if (IS_INDEX) nxt = {{(DW-8){1'b0}}, q[7:0]};
            end else if (wr_en && (wr_sel == reg_sel_e'(i))) begin
                nxt = wr_byte ? {q[DW-1:8], wr_data[7:0]} : wr_data;
            end
            if (IS_INDEX && idx8_next) nxt[DW-1:8] = '0;
        end

        // Register storage, zero at power-on.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end
    end

    assign a_q = g_reg[0].q;
    assign x_q = g_reg[1].q;
    assign y_q = g_reg[2].q;

    AST_IDX_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        idx8_q |-> (x_q[DW-1:8] == '0 && y_q[DW-1:8] == '0)); // R5
    AST_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_A && wr_byte && !warm_rst) |=> (a_q[DW-1:8] == $past(a_q[DW-1:8]))); // R4

endmodule

// File: rtl/crs_stack.sv
// Stack pointer with the page-one rule applied while emulation mode is on.
// Assumes emu_next is the emulation flag that the same edge will store.
module crs_stack
    import cpu_reg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          wr_sp,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    input  logic          emu_next,
    input  logic          emu_q,
    output logic [DW-1:0] sp_q
);

    localparam logic [DW-9:0] PAGE_ONE = {{(DW-9){1'b0}}, 1'b1};
    localparam logic [DW-1:0] SP_POWER = {PAGE_ONE, 8'hFF};

    logic [DW-1:0] raw;
    logic [DW-1:0] nxt;

    // Pick the candidate value, then pin it when emulation is on.
    always_comb begin
        raw = sp_q;
        if (!warm_rst && wr_sp) raw = wr_byte ? {sp_q[DW-1:8], wr_data[7:0]} : wr_data;
        nxt = emu_next ? {PAGE_ONE, raw[7:0]} : raw;
    end

    // Stack pointer storage.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= SP_POWER;
        else        sp_q <= nxt;
    end

    AST_SP_PAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        emu_q |-> (sp_q[DW-1:8] == PAGE_ONE)); // R3

endmodule

// File: rtl/cpu_reg_status.sv
// Top: register and status unit of a dual-mode CPU core.
// Holds mode flag, direct page, banks and cycle counter; routes the write port.
// Assumes at most one register write per cycle on the shared write port.
module cpu_reg_status
    import cpu_reg_pkg::*;
#(
    parameter int DW     = 16,
    parameter int BANK_W = 8,
    parameter int CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic              wr_byte,
    input  logic              wr_nz,
    input  logic [DW-1:0]     wr_data,
    input  logic              ps_we,
    input  logic [7:0]        ps_data,
    input  logic [7:0]        flg_clr,
    input  logic [7:0]        flg_set,
    input  logic              emu_we,
    input  logic              emu_data,
    input  logic [7:0]        test_mask,
    output logic              test_hit,
    output logic [DW-1:0]     a_q,
    output logic [DW-1:0]     x_q,
    output logic [DW-1:0]     y_q,
    output logic [DW-1:0]     sp_q,
    output logic [DW-1:0]     dp_q,
    output logic [BANK_W-1:0] dbank_q,
    output logic [BANK_W-1:0] pbank_q,
    output logic [7:0]        ps_q,
    output logic              emu_q,
    output logic [CYC_W-1:0]  cyc_q
);

    reg_sel_e   sel;
    logic       emu_next;
    logic [7:0] p_next;
    logic       wr_live;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_live = wr_en && !warm_rst;

    // Emulation flag: forced on by warm reset, else written on strobe.
    always_comb begin
        emu_next = emu_q;
        if (warm_rst)    emu_next = 1'b1;
        else if (emu_we) emu_next = emu_data;
    end

    // Mode flag, direct page and bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_rst) begin
            emu_q   <= 1'b1;
            dp_q    <= '0;
            dbank_q <= '0;
            pbank_q <= '0;
        end else begin
            emu_q <= emu_next;
            if (wr_live && sel == SEL_DP)
                dp_q <= wr_byte ? {dp_q[DW-1:8], wr_data[7:0]} : wr_data;
            if (wr_live && sel == SEL_DBANK) dbank_q <= wr_data[BANK_W-1:0];
            if (wr_live && sel == SEL_PBANK) pbank_q <= wr_data[BANK_W-1:0];
        end
    end

    // Free-running cycle counter, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_rst) cyc_q <= '0;
        else                    cyc_q <= cyc_q + {{(CYC_W-1){1'b0}}, 1'b1};
    end

    crs_status #(.DW(DW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst  (warm_rst),
        .ps_we     (ps_we),
        .ps_data   (ps_data),
        .flg_clr   (flg_clr),
        .flg_set   (flg_set),
        .nz_en     (wr_en && wr_nz),
        .nz_byte   (wr_byte),
        .nz_val    (wr_data),
        .test_mask (test_mask),
        .p_q       (ps_q),
        .p_next    (p_next),
        .test_hit  (test_hit)
    );

    crs_gpr #(.DW(DW)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst  (warm_rst),
        .wr_en     (wr_en),
        .wr_sel    (sel),
        .wr_byte   (wr_byte),
        .wr_data   (wr_data),
        .idx8_next (p_next[FLG_X]),
        .idx8_q    (ps_q[FLG_X]),
        .a_q       (a_q),
        .x_q       (x_q),
        .y_q       (y_q)
    );

    crs_stack #(.DW(DW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_rst (warm_rst),
        .wr_sp    (wr_en && sel == SEL_SP),
        .wr_byte  (wr_byte),
        .wr_data  (wr_data),
        .emu_next (emu_next),
        .emu_q    (emu_q),
        .sp_q     (sp_q)
    );

    AST_WARM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (emu_q && dp_q == '0 && dbank_q == '0 && pbank_q == '0)); // R8
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst |=> (cyc_q == $past(cyc_q) + {{(CYC_W-1){1'b0}}, 1'b1})); // R9

endmodule

// File: tb/sim_cpu_reg_status.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_cpu_reg_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic        wr_byte = 1'b0;
    logic        wr_nz = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ps_we = 1'b0;
    logic [7:0]  ps_data = '0;
    logic [7:0]  flg_clr = '0;
    logic [7:0]  flg_set = '0;
    logic        emu_we = 1'b0;
    logic        emu_data = 1'b0;
    logic [7:0]  test_mask = '0;
    logic        test_hit;
    logic [15:0] a_q, x_q, y_q, sp_q, dp_q;
    logic [7:0]  dbank_q, pbank_q, ps_q;
    logic        emu_q;
    logic [31:0] cyc_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cpu_reg_status u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_byte(wr_byte), .wr_nz(wr_nz), .wr_data(wr_data), .ps_we(ps_we), .ps_data(ps_data),
        .flg_clr(flg_clr), .flg_set(flg_set), .emu_we(emu_we), .emu_data(emu_data),
        .test_mask(test_mask), .test_hit(test_hit), .a_q(a_q), .x_q(x_q), .y_q(y_q),
        .sp_q(sp_q), .dp_q(dp_q), .dbank_q(dbank_q), .pbank_q(pbank_q), .ps_q(ps_q),
        .emu_q(emu_q), .cyc_q(cyc_q)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One clock; inputs set before are captured, then cleared.
    task automatic step();
        @(posedge clk);
        #1;
        warm_rst = 0; wr_en = 0; wr_sel = 3'd7; wr_byte = 0; wr_nz = 0; wr_data = '0;
        ps_we = 0; ps_data = '0; flg_clr = '0; flg_set = '0; emu_we = 0; emu_data = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic bytew, input logic [15:0] d, input logic nz);
        wr_en = 1; wr_sel = sel; wr_byte = bytew; wr_data = d; wr_nz = nz;
        step();
    endtask

    task automatic t_power_on();
        chk("R1", "sp", sp_q, 16'h01FF);
        chk("R1", "ps", ps_q, 8'h34);
        chk("R1", "emu", emu_q, 1);
        chk("R1", "a|x|y|dp", a_q | x_q | y_q | dp_q, 0);
        chk("R1", "banks", {dbank_q, pbank_q}, 0);
        chk("R9", "cycle at start", cyc_q, 0);
    endtask

    task automatic t_flag_test();
        test_mask = 8'h34; #1;
        chk("R2", "test I|M|X", test_hit, 1);
        test_mask = 8'h35; #1;
        chk("R2", "test with C", test_hit, 0);
        test_mask = 8'h00; #1;
        chk("R2", "empty mask", test_hit, 1);
    endtask

    task automatic t_sp_rule();
        wr(3'd3, 0, 16'hABCD, 0);
        chk("R3", "sp pinned", sp_q, 16'h01CD);
        emu_we = 1; emu_data = 0; step();
        chk("R3", "emu off", emu_q, 0);
        wr(3'd3, 0, 16'hABCD, 0);
        chk("R3", "sp full", sp_q, 16'hABCD);
        emu_we = 1; emu_data = 1; step();
        chk("R3", "sp pinned on entry", sp_q, 16'h01CD);
        emu_we = 1; emu_data = 0; step();
    endtask

    task automatic t_byte_write();
        flg_clr = 8'h30; step();
        chk("R2", "ps after clr", ps_q, 8'h04);
        wr(3'd0, 0, 16'h1234, 0);
        chk("R4", "a full", a_q, 16'h1234);
        wr(3'd0, 1, 16'hFFAB, 0);
        chk("R4", "a byte", a_q, 16'h12AB);
        wr(3'd1, 0, 16'hBEEF, 0);
        chk("R4", "x full", x_q, 16'hBEEF);
        wr(3'd4, 0, 16'h2000, 0);
        chk("R4", "dp full", dp_q, 16'h2000);
        wr(3'd5, 0, 16'h1177, 0);
        chk("R4", "dbank low byte", dbank_q, 8'h77);
    endtask

    task automatic t_index_trunc();
        wr(3'd2, 0, 16'hCAFE, 0);
        flg_set = 8'h10; step();
        chk("R5", "x trunc by set", x_q, 16'h00EF);
        chk("R5", "y trunc by set", y_q, 16'h00FE);
        wr(3'd1, 0, 16'h5566, 0);
        chk("R5", "16-bit x write while 8-bit", x_q, 16'h0066);
        ps_we = 1; ps_data = 8'h00; step();
        wr(3'd1, 0, 16'h5566, 0);
        chk("R5", "x wide when flag clear", x_q, 16'h5566);
        ps_we = 1; ps_data = 8'h10; step();
        chk("R5", "x trunc by status load", x_q, 16'h0066);
    endtask

    task automatic t_nz();
        wr(3'd0, 1, 16'h0000, 1);
        chk("R6", "byte zero", ps_q, 8'h12);
        wr(3'd0, 1, 16'h0080, 1);
        chk("R6", "byte negative", ps_q, 8'h90);
        wr(3'd0, 0, 16'h0080, 1);
        chk("R6", "word bit7 not negative", ps_q, 8'h10);
        wr(3'd0, 0, 16'h8000, 1);
        chk("R6", "word negative", ps_q, 8'h90);
        wr(3'd0, 1, 16'h0000, 1);
        chk("R6", "byte zero, high kept", ps_q, 8'h12);
        chk("R4", "a high kept", a_q, 16'h8000);
    endtask

    task automatic t_masks();
        flg_clr = 8'hFF; flg_set = 8'h41; step();
        chk("R7", "clear then set", ps_q, 8'h41);
        ps_we = 1; ps_data = 8'h5A; flg_clr = 8'hFF; flg_set = 8'h01; step();
        chk("R7", "load wins", ps_q, 8'h5A);
        flg_set = 8'h82; wr(3'd0, 1, 16'h0001, 1);
        chk("R7", "nz after masks", ps_q, 8'h58);
    endtask

    task automatic t_warm();
        flg_clr = 8'h10; step();
        chk("R2", "ps before warm", ps_q, 8'h48);
        wr(3'd1, 0, 16'h1234, 0);
        wr(3'd2, 0, 16'h5678, 0);
        wr(3'd3, 0, 16'h3456, 0);
        wr(3'd0, 0, 16'h9ABC, 0);
        wr(3'd6, 0, 16'h0033, 0);
        wr(3'd5, 0, 16'h0044, 0);
        warm_rst = 1; wr(3'd0, 0, 16'hFFFF, 1);
        chk("R8", "ps", ps_q, 8'h74);
        chk("R8", "emu", emu_q, 1);
        chk("R8", "x", x_q, 16'h0034);
        chk("R8", "y", y_q, 16'h0078);
        chk("R8", "sp", sp_q, 16'h0156);
        chk("R8", "a kept, write ignored", a_q, 16'h9ABC);
        chk("R8", "dp/banks", {dp_q, dbank_q, pbank_q}, 0);
        chk("R9", "cycle after warm", cyc_q, 0);
        step();
        chk("R9", "cycle one later", cyc_q, 1);
    endtask

    task automatic t_cycle();
        logic [31:0] c0;
        c0 = cyc_q;
        for (int i = 0; i < 5; i++) step();
        chk("R9", "cycle +5", cyc_q, c0 + 5);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_power_on();
        t_flag_test();
        t_sp_rule();
        t_byte_write();
        t_index_trunc();
        t_nz();
        t_masks();
        t_cycle();
        t_warm();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule